// File: doc/BRIEF.md
# Swept-Frequency NCO Phase Generator

This block produces the phase word that drives a quadrature sine/cosine table in a digital downconverter. The frequency is not a constant. A small control machine keeps a 32-bit phase step and, on each enabled cycle, moves it by a programmable delta. It moves up or down as a mode input selects, and it stays between a programmed floor and ceiling. The result is a linear frequency chirp.

The current step is added to a 32-bit phase accumulator, and the accumulator's carry is brought out. The top 18 bits of the accumulated phase, plus an 18-bit phase offset, are registered as the output phase word.

Software-side logic writes the floor, ceiling and delta through a single load strobe. It then starts a sweep by forcing the step to the floor or to the ceiling.

The step controller has three states:
- `ST_IDLE` is the state after reset. The step is held and never moves.
- `ST_SWEEP` steps the step by the delta on every enabled cycle.
- `ST_PINNED` holds the step at the limit it reached.

The transitions are:
- IDLE→SWEEP and PINNED→SWEEP, on either initialise control.
- SWEEP→SWEEP, also on either initialise control (a restart).
- SWEEP→PINNED, when a step would cross a limit.
- Any state→IDLE, on reset.

Top module: `sweep_phase_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the phase accumulator, the step, the floor/ceiling/delta registers, `phase_word` and `carry_out` to zero, and returns the controller to `ST_IDLE`.
- R2: When `load` is high at an edge, `min_step`, `max_step` and `delta_step` are captured. The captured values are used from the next edge on. A load by itself does not change the step or the phase.
- R3: `init_min` high at an edge sets the step to the captured floor, and `init_max` high sets it to the captured ceiling. `init_min` wins when both are high. Either one enters `ST_SWEEP`, and either one acts whether `en` is high or low.
- R4: In `ST_SWEEP` with `en` high and `sweep_up` = 1, the step increases by the delta at each edge.
- R5: In `ST_SWEEP` with `en` high and `sweep_up` = 0, the step decreases by the delta at each edge.
- R6: An upward step that would exceed the ceiling (including 32-bit overflow) loads the ceiling and enters `ST_PINNED`. There the step holds, whatever `sweep_up` does, until the next initialise.
- R7: A downward step that would go below the floor (including borrow) loads the floor and enters `ST_PINNED`.
- R8: With `en` low, the accumulator and the step hold, and `carry_out` reads 0 after that edge.
- R9: At each enabled edge the accumulator adds the step that was in force before the edge, modulo 2^32. `carry_out` is 1 for exactly the cycle after an enabled update that wrapped.
- R10: `phase_word` equals (accumulator bits 31:14 + `phase_ofs`) mod 2^18, registered one edge after the accumulator value. No overflow flag exists.
- R11: In `ST_IDLE` the step does not change on enabled cycles, so after reset the phase stays at zero until an initialise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance both accumulators |
| load | input | 1 | Capture floor, ceiling and delta |
| init_min | input | 1 | Force step to floor, start sweep |
| init_max | input | 1 | Force step to ceiling, start sweep |
| sweep_up | input | 1 | 1 = add delta, 0 = subtract delta |
| min_step | input | 32 | Step floor |
| max_step | input | 32 | Step ceiling |
| delta_step | input | 32 | Step change per enabled cycle |
| phase_ofs | input | 18 | Offset added to the phase word |
| phase_word | output | 18 | Registered phase to the sin/cos table |
| carry_out | output | 1 | Accumulator wrap, one-cycle pulse |

## Verification
The step register is not visible at the ports. A wrong step value shows up in `phase_word` one edge after the accumulator absorbs it, that is, two edges after the bad step is written. From then on the phase slope stays wrong and the error grows every cycle. A controller stuck in the wrong state appears either as a phase slope that keeps bending past a limit, or as one that stops changing too early. A missed or false wrap appears on `carry_out` in the cycle right after the wrapping update. The bench therefore compares both outputs against a cycle model on every edge.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
    localparam int ACC_W = 32;
    localparam int OUT_W = 18;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SWEEP  = 2'd1,
        ST_PINNED = 2'd2
    } step_state_t;
endpackage

// File: rtl/sweep_limit_regs.sv
module sweep_limit_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] min_i,
    input  logic [W-1:0] max_i,
    input  logic [W-1:0] delta_i,
    output logic [W-1:0] min_q,
    output logic [W-1:0] max_q,
    output logic [W-1:0] delta_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            min_q   <= '0;
            max_q   <= '0;
            delta_q <= '0;
        end else if (load) begin
            min_q   <= min_i;
            max_q   <= max_i;
            delta_q <= delta_i;
        end
    end

    // limits keep their value unless a load strobe occurs
    assert_limits_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(min_q) && $stable(max_q) && $stable(delta_q)))
        else $error("limit register changed without load");
endmodule

// File: rtl/sweep_step_ctrl.sv
module sweep_step_ctrl
    import sweep_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         init_min,
    input  logic         init_max,
    input  logic         sweep_up,
    input  logic [W-1:0] floor_i,
    input  logic [W-1:0] ceil_i,
    input  logic [W-1:0] delta_i,
    output logic [W-1:0] step_o
);
    step_state_t  state_q, state_d;
    logic [W-1:0] step_q, step_d;
    logic [W:0]   sum_w, diff_w;
    logic         over_ceil, under_floor;

    assign sum_w       = {1'b0, step_q} + {1'b0, delta_i};
    assign diff_w      = {1'b0, step_q} - {1'b0, delta_i};
    assign over_ceil   = sum_w[W] || (sum_w[W-1:0] > ceil_i);
    assign under_floor = diff_w[W] || (diff_w[W-1:0] < floor_i);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // next state and step value
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_IDLE;
            end
            ST_SWEEP: begin
                if (en) begin
                    if (sweep_up) begin
                        if (over_ceil) begin
                            step_d  = ceil_i;
                            state_d = ST_PINNED;
                        end else begin
                            step_d = sum_w[W-1:0];
                        end
                    end else begin
                        if (under_floor) begin
                            step_d  = floor_i;
                            state_d = ST_PINNED;
                        end else begin
                            step_d = diff_w[W-1:0];
                        end
                    end
                end
            end
            ST_PINNED: begin
                state_d = ST_PINNED;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (init_min) begin
            step_d  = floor_i;
            state_d = ST_SWEEP;
        end else if (init_max) begin
            step_d  = ceil_i;
            state_d = ST_SWEEP;
        end
    end

    assign step_o = step_q;

    assert_init_floor_R3: assert property (@(posedge clk) disable iff (rst)
        init_min |=> (step_q == $past(floor_i)))
        else $error("init to floor did not load floor");

    assert_up_never_drops_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SWEEP && en && sweep_up && !init_min && !init_max && step_q <= ceil_i)
        |=> (step_q >= $past(step_q)))
        else $error("upward sweep decreased the step");

    assert_down_never_rises_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SWEEP && en && !sweep_up && !init_min && !init_max && step_q >= floor_i)
        |=> (step_q <= $past(step_q)))
        else $error("downward sweep increased the step");

    assert_pinned_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PINNED && !init_min && !init_max) |=> ($stable(step_q) && state_q == ST_PINNED))
        else $error("pinned step moved");

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !init_min && !init_max) |=> $stable(step_q))
        else $error("idle step moved");
endmodule

// File: rtl/sweep_phase_acc.sv
module sweep_phase_acc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] step_i,
    output logic [W-1:0] acc_o,
    output logic         carry_o
);
    logic [W-1:0] acc_q;
    logic         carry_q;
    logic [W:0]   acc_sum;

    assign acc_sum = {1'b0, acc_q} + {1'b0, step_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (en) begin
            acc_q   <= acc_sum[W-1:0];
            carry_q <= acc_sum[W];
        end else begin
            carry_q <= 1'b0;
        end
    end

    assign acc_o   = acc_q;
    assign carry_o = carry_q;

    assert_stall_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(acc_q) && !carry_q))
        else $error("accumulator moved while stalled");

    assert_carry_needs_en_R9: assert property (@(posedge clk) disable iff (rst)
        carry_q |-> $past(en))
        else $error("carry without an enabled update");
endmodule

// File: rtl/sweep_phase_out.sv
module sweep_phase_out #(
    parameter int W  = 32,
    parameter int OW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  acc_i,
    input  logic [OW-1:0] ofs_i,
    output logic [OW-1:0] word_o
);
    localparam int TOP_LSB = W - OW;

    logic [OW-1:0] acc_top;
    logic [OW-1:0] word_q;

    assign acc_top = acc_i[W-1:TOP_LSB];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= acc_top + ofs_i;
        end
    end

    assign word_o = word_q;

    assert_word_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(acc_top) && $stable(ofs_i)) |=> $stable(word_q))
        else $error("phase word changed with steady inputs");
endmodule

// File: rtl/sweep_phase_gen.sv
module sweep_phase_gen
    import sweep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic             init_min,
    input  logic             init_max,
    input  logic             sweep_up,
    input  logic [ACC_W-1:0] min_step,
    input  logic [ACC_W-1:0] max_step,
    input  logic [ACC_W-1:0] delta_step,
    input  logic [OUT_W-1:0] phase_ofs,
    output logic [OUT_W-1:0] phase_word,
    output logic             carry_out
);
    logic [ACC_W-1:0] floor_q, ceil_q, delta_q;
    logic [ACC_W-1:0] step_w;
    logic [ACC_W-1:0] acc_w;

    sweep_limit_regs #(.W(ACC_W)) u_limits (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .min_i   (min_step),
        .max_i   (max_step),
        .delta_i (delta_step),
        .min_q   (floor_q),
        .max_q   (ceil_q),
        .delta_q (delta_q)
    );

    sweep_step_ctrl #(.W(ACC_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .init_min (init_min),
        .init_max (init_max),
        .sweep_up (sweep_up),
        .floor_i  (floor_q),
        .ceil_i   (ceil_q),
        .delta_i  (delta_q),
        .step_o   (step_w)
    );

    sweep_phase_acc #(.W(ACC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .step_i  (step_w),
        .acc_o   (acc_w),
        .carry_o (carry_out)
    );

    sweep_phase_out #(.W(ACC_W), .OW(OUT_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .acc_i  (acc_w),
        .ofs_i  (phase_ofs),
        .word_o (phase_word)
    );
endmodule

// File: tb/sweep_phase_gen_tb.sv
module sweep_phase_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0, load = 1'b0, init_min = 1'b0, init_max = 1'b0, sweep_up = 1'b1;
    logic [31:0] min_step = '0, max_step = '0, delta_step = '0;
    logic [17:0] phase_ofs = '0;
    logic [17:0] phase_word;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // reference model state
    logic [31:0] m_acc, m_step, m_lo, m_hi, m_dl;
    logic [17:0] m_word;
    logic        m_carry;
    int          m_st; // 0 idle, 1 sweep, 2 pinned

    always #(CLK_PERIOD/2) clk = ~clk;

    sweep_phase_gen u_dut (
        .clk(clk), .rst(rst), .en(en), .load(load), .init_min(init_min),
        .init_max(init_max), .sweep_up(sweep_up), .min_step(min_step),
        .max_step(max_step), .delta_step(delta_step), .phase_ofs(phase_ofs),
        .phase_word(phase_word), .carry_out(carry_out)
    );

    task automatic model_edge();
        logic [32:0] s;
        logic [31:0] n_step;
        int          n_st;
        if (rst) begin
            m_acc = 0; m_step = 0; m_lo = 0; m_hi = 0; m_dl = 0;
            m_word = 0; m_carry = 0; m_st = 0;
            return;
        end
        m_word = m_acc[31:14] + phase_ofs;
        n_step = m_step;
        n_st   = m_st;
        if (init_min) begin
            n_step = m_lo; n_st = 1;
        end else if (init_max) begin
            n_step = m_hi; n_st = 1;
        end else if (en && m_st == 1) begin
            if (sweep_up) begin
                s = {1'b0, m_step} + {1'b0, m_dl};
                if (s[32] || s[31:0] > m_hi) begin n_step = m_hi; n_st = 2; end
                else n_step = s[31:0];
            end else begin
                s = {1'b0, m_step} - {1'b0, m_dl};
                if (s[32] || s[31:0] < m_lo) begin n_step = m_lo; n_st = 2; end
                else n_step = s[31:0];
            end
        end
        if (en) begin
            s = {1'b0, m_acc} + {1'b0, m_step};
            m_acc = s[31:0]; m_carry = s[32];
        end else begin
            m_carry = 0;
        end
        m_step = n_step;
        m_st   = n_st;
        if (load) begin
            m_lo = min_step; m_hi = max_step; m_dl = delta_step;
        end
    endtask

    task automatic check_ports();
        checks++;
        if (phase_word !== m_word || carry_out !== m_carry) begin
            errors++;
            $display("FAIL %s: phase_word=%h carry_out=%b expected phase_word=%h carry_out=%b",
                     cur_req, phase_word, carry_out, m_word, m_carry);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check_ports();
        end
    endtask

    task automatic load_limits(logic [31:0] lo, logic [31:0] hi, logic [31:0] dl);
        min_step = lo; max_step = hi; delta_step = dl; load = 1'b1;
        tick();
        load = 1'b0;
    endtask

    task automatic t_reset();
        cur_req = "R1";
        rst = 1'b1; en = 1'b1;
        tick(2);
        rst = 1'b0; en = 1'b0;
    endtask

    task automatic t_idle();
        cur_req = "R11";
        en = 1'b1;
        tick(5);
    endtask

    task automatic t_load_only();
        cur_req = "R2";
        load_limits(32'h0010_0000, 32'h0040_0000, 32'h0008_0000);
        tick(4);
    endtask

    task automatic t_sweep_up_clamp();
        cur_req = "R4";
        sweep_up = 1'b1; init_min = 1'b1;
        tick();
        init_min = 1'b0;
        tick(6);
        cur_req = "R6";
        tick(3);
        sweep_up = 1'b0; // pinned must ignore direction
        tick(5);
    endtask

    task automatic t_sweep_down_clamp();
        cur_req = "R5";
        sweep_up = 1'b0; init_max = 1'b1;
        tick();
        init_max = 1'b0;
        tick(6);
        cur_req = "R7";
        tick(4);
    endtask

    task automatic t_priority();
        cur_req = "R3";
        init_min = 1'b1; init_max = 1'b1; en = 1'b0;
        tick();
        init_min = 1'b0; init_max = 1'b0; en = 1'b1; sweep_up = 1'b1;
        tick(3);
    endtask

    task automatic t_stall();
        cur_req = "R8";
        en = 1'b0;
        tick(4);
        en = 1'b1;
        tick(2);
    endtask

    task automatic t_wrap();
        cur_req = "R9";
        load_limits(32'hC000_0001, 32'hF000_0000, 32'h0000_0000);
        init_min = 1'b1;
        tick();
        init_min = 1'b0;
        tick(12);
    endtask

    task automatic t_offset();
        cur_req = "R10";
        phase_ofs = 18'h3FFF0;
        tick(6);
        phase_ofs = 18'h2AAAA;
        tick(6);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        t_load_only();
        t_sweep_up_clamp();
        t_sweep_down_clamp();
        t_priority();
        t_stall();
        t_wrap();
        t_offset();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule